// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an eight-pin general-purpose I/O port behind a small byte-wide register interface. The interface has an address, a write strobe, write data and read data. The port keeps one stored output value and one direction bit per pin. It drives the pad output and pad output-enable straight from that state. Pad inputs pass through a synchroniser so that software can read them back.

The data register takes up the whole address window below the direction register. The address itself carries a per-pin mask: address bit n+2 selects pin n. Software can therefore set, clear or sample any subset of pins in one access, with no read-modify-write and no lock around it. A data write reaches only pins that are both selected by the address and configured as outputs. A write aimed at an input pin is dropped, so software writes the value again after it turns the pin into an output. Reads are combinational: read data follows the address in the same cycle.

Top module: `maskgpio_port`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), every direction bit is 0 (input), every stored output bit is 0, and pad_oe and pad_out are both 0.
- R2: A write to any address below 0x400 updates stored output bit n only if address bit n+2 is 1. Output bits whose address bit is 0 keep their value.
- R3: A data write leaves the stored output bit of a pin whose direction bit is 0 unchanged. The old value is visible on pad_out after that pin is switched to output.
- R4: A read of any address below 0x400 returns 0 in every bit n whose address bit n+2 is 0.
- R5: Address 0x400 holds the direction register. A write stores bus_wdata, and a read returns the stored value. Bit n set to 1 means pin n is an output.
- R6: pad_oe[n] always equals direction bit n, and pad_out[n] always equals stored output bit n. Both change at the rising edge that takes the write.
- R7: When bit n of a data read is selected and pin n is an input, that bit returns pad_in[n] delayed by two flops. A change of pad_in is not visible after the first rising edge and is visible after the second.
- R8: When bit n of a data read is selected and pin n is an output, that bit returns the stored output bit, whatever the value of pad_in[n].
- R9: Any address of 0x401 or above, other than 0x400 itself, reads as 0. Writes to such an address change neither pad_oe nor pad_out.
- R10: bus_rdata depends only on the current address and the current state. It is valid in the same cycle the address is presented, with no wait cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (12) | Byte address of the access |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | NPINS (8) | Write data |
| bus_rdata | output | NPINS (8) | Combinational read data for bus_addr |
| pad_in | input | NPINS (8) | Asynchronous pad input levels |
| pad_out | output | NPINS (8) | Pad output values |
| pad_oe | output | NPINS (8) | Pad output enables, 1 = driven |

## Verification
The bench sweeps all 256 address masks for data writes and data reads under several direction patterns. A mask decoded off by one bit position, or a write that ignores the mask, corrupts neighbouring pins. A read that leaves unmasked bits set shows up as non-zero bits outside the mask. It writes to pins while they are inputs and then turns them into outputs. A design that lets input-pin writes through shows the new value instead of the held one. It moves pad_in and reads back after one edge and after two. A synchroniser that is too short or too long is caught on one of the two reads. It also drives pad_in opposite to the driven value on output pins. This catches a readback that always samples the pad. Finally, it hits offsets just above the direction register and at the top of the address space. Loose decoding of those offsets either aliases the direction register or returns stray data.

// File: rtl/mgp_pkg.sv
package mgp_pkg;

  // Kind of register an address falls into.
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_DATA = 2'd1,
    ACC_DIR  = 2'd2
  } acc_kind_e;

  // Default byte offset of the direction register.
  localparam int unsigned DIR_OFFSET_DEF = 32'h400;

endpackage

// File: rtl/mgp_decode.sv
module mgp_decode #(
  parameter int unsigned NPINS   = 8,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DIR_OFF = mgp_pkg::DIR_OFFSET_DEF
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               we,
  output mgp_pkg::acc_kind_e kind,
  output logic [NPINS-1:0]   lane_mask,
  output logic               data_wr,
  output logic               dir_wr
);
  import mgp_pkg::*;

  localparam int unsigned MASK_LSB = 2;
  localparam int unsigned MASK_MSB = NPINS + MASK_LSB - 1;
  localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(DIR_OFF);

  // The data window must cover all mask bits and must fit in the address.
  if ((1 << (MASK_MSB + 1)) > DIR_OFF) begin : g_bad_window
    $error("mgp_decode: data window too small for NPINS");
  end
  if (ADDR_W <= MASK_MSB + 1) begin : g_bad_addr
    $error("mgp_decode: ADDR_W too narrow");
  end

  // Per-pin selection carried in the address.
  function automatic logic [NPINS-1:0] mask_of(input logic [ADDR_W-1:0] a);
    return a[MASK_MSB:MASK_LSB];
  endfunction

  function automatic acc_kind_e classify(input logic [ADDR_W-1:0] a);
    if (a < DIR_ADDR)       return ACC_DATA;
    else if (a == DIR_ADDR) return ACC_DIR;
    else                    return ACC_NONE;
  endfunction

  always_comb begin
    kind      = classify(addr);
    lane_mask = mask_of(addr);
    data_wr   = we && (kind == ACC_DATA);
    dir_wr    = we && (kind == ACC_DIR);
  end

endmodule

// File: rtl/mgp_regs.sv
module mgp_regs #(
  parameter int unsigned NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_wr,
  input  logic             dir_wr,
  input  logic [NPINS-1:0] lane_mask,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] out_q
);

  // A pin's stored value accepts a data write only when selected and output.
  function automatic logic lane_takes(input logic sel, input logic is_out);
    return sel && is_out;
  endfunction

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dir_q[n] <= 1'b0;
      end else if (dir_wr) begin
        dir_q[n] <= wdata[n];
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        out_q[n] <= 1'b0;
      end else if (data_wr && lane_takes(lane_mask[n], dir_q[n])) begin
        out_q[n] <= wdata[n];
      end
    end
  end

endmodule

// File: rtl/mgp_sync.sv
module mgp_sync #(
  parameter int unsigned NPINS  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] async_in,
  output logic [NPINS-1:0] sync_out
);

  if (STAGES < 2) begin : g_bad_stages
    $error("mgp_sync: at least two stages required");
  end

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        chain_q <= '0;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], async_in[n]};
      end
    end
    assign sync_out[n] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/mgp_rdmux.sv
module mgp_rdmux #(
  parameter int unsigned NPINS = 8
) (
  input  mgp_pkg::acc_kind_e kind,
  input  logic [NPINS-1:0]   lane_mask,
  input  logic [NPINS-1:0]   dir_q,
  input  logic [NPINS-1:0]   out_q,
  input  logic [NPINS-1:0]   in_sync,
  output logic [NPINS-1:0]   rdata
);
  import mgp_pkg::*;

  // What a pin reads as: driven value when output, sampled pad when input.
  function automatic logic [NPINS-1:0] pin_view(input logic [NPINS-1:0] d,
                                                input logic [NPINS-1:0] o,
                                                input logic [NPINS-1:0] s);
    return (d & o) | (~d & s);
  endfunction

  always_comb begin
    unique case (kind)
      ACC_DATA: rdata = pin_view(dir_q, out_q, in_sync) & lane_mask;
      ACC_DIR:  rdata = dir_q;
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/maskgpio_port.sv
module maskgpio_port #(
  parameter int unsigned NPINS   = 8,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DIR_OFF = mgp_pkg::DIR_OFFSET_DEF,
  parameter int unsigned SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe
);
  import mgp_pkg::*;

  acc_kind_e        acc_kind;
  logic [NPINS-1:0] lane_mask;
  logic             data_wr;
  logic             dir_wr;
  logic             data_sel;
  logic             dir_sel;
  logic [NPINS-1:0] dir_q;
  logic [NPINS-1:0] out_q;
  logic [NPINS-1:0] in_sync;

  mgp_decode #(.NPINS(NPINS), .ADDR_W(ADDR_W), .DIR_OFF(DIR_OFF)) u_decode (
    .addr      (bus_addr),
    .we        (bus_we),
    .kind      (acc_kind),
    .lane_mask (lane_mask),
    .data_wr   (data_wr),
    .dir_wr    (dir_wr)
  );

  mgp_regs #(.NPINS(NPINS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_wr   (data_wr),
    .dir_wr    (dir_wr),
    .lane_mask (lane_mask),
    .wdata     (bus_wdata),
    .dir_q     (dir_q),
    .out_q     (out_q)
  );

  mgp_sync #(.NPINS(NPINS), .STAGES(SYNC_N)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (in_sync)
  );

  mgp_rdmux #(.NPINS(NPINS)) u_rdmux (
    .kind      (acc_kind),
    .lane_mask (lane_mask),
    .dir_q     (dir_q),
    .out_q     (out_q),
    .in_sync   (in_sync),
    .rdata     (bus_rdata)
  );

  // Named access events for the checker.
  assign data_sel = (acc_kind == ACC_DATA);
  assign dir_sel  = (acc_kind == ACC_DIR);

  assign pad_oe  = dir_q;
  assign pad_out = out_q;

endmodule

// File: rtl/mgp_checker.sv
module mgp_checker #(
  parameter int unsigned NPINS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] bus_wdata,
  input logic [NPINS-1:0] bus_rdata,
  input logic [NPINS-1:0] pad_out,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] lane_mask,
  input logic             data_wr,
  input logic             dir_wr,
  input logic             data_sel,
  input logic             dir_sel
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> (pad_oe == '0 && pad_out == '0)); // R1

  AST_UNMASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> ((pad_out ^ $past(pad_out)) & ~$past(lane_mask)) == '0); // R2

  AST_INPUT_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> ((pad_out ^ $past(pad_out)) & ~$past(pad_oe)) == '0); // R3

  AST_RDATA_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    data_sel |-> (bus_rdata & ~lane_mask) == '0); // R4

  AST_DIR_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    dir_sel |-> bus_rdata == pad_oe); // R5

  AST_OE_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr |=> pad_oe == $past(bus_wdata)); // R6

  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_wr && !dir_wr) |=> ($stable(pad_oe) && $stable(pad_out))); // R9

  AST_UNIMPL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_sel && !dir_sel) |-> bus_rdata == '0); // R9

endmodule

bind maskgpio_port mgp_checker #(.NPINS(NPINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .lane_mask (lane_mask),
  .data_wr   (data_wr),
  .dir_wr    (dir_wr),
  .data_sel  (data_sel),
  .dir_sel   (dir_sel)
);

// File: tb/maskgpio_port_tb.sv
module maskgpio_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [7:0]  pad_in = '0;
  logic [7:0]  pad_out;
  logic [7:0]  pad_oe;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [7:0] m_dir = '0;
  logic [7:0] m_out = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  maskgpio_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // Data address carrying pin mask m in bits [9:2].
  function automatic logic [11:0] data_addr(input logic [7:0] m);
    return {2'b00, m, 2'b00};
  endfunction

  task automatic bus_wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [7:0] d);
    bus_we = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic set_dir(input logic [7:0] d);
    bus_wr(12'h400, d);
    m_dir = d;
  endtask

  task automatic data_wr(input logic [7:0] m, input logic [7:0] d);
    bus_wr(data_addr(m), d);
    m_out = (m_out & ~(m & m_dir)) | (d & m & m_dir);
  endtask

  initial begin : watchdog
    for (int c = 0; c < WATCHDOG; c++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : stim
    logic [7:0] rd;
    logic [7:0] dir_pats [4];
    logic [7:0] pin_val;
    logic [11:0] bad_addrs [6];
    dir_pats = '{8'h00, 8'hFF, 8'hA5, 8'h3C};
    bad_addrs = '{12'h401, 12'h404, 12'h408, 12'h7FC, 12'h800, 12'hFFC};

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 pad_out", pad_out, 8'h00);
    bus_rd(12'h400, rd); chk("R1 dir", rd, 8'h00);
    bus_rd(data_addr(8'hFF), rd); chk("R1 data", rd, 8'h00);

    pad_in = 8'h96;
    repeat (3) @(negedge clk);

    // R2/R4/R6/R8 sweep: every mask under several direction patterns
    foreach (dir_pats[p]) begin
      set_dir(dir_pats[p]);
      chk("R6 oe", pad_oe, m_dir);
      bus_rd(12'h400, rd); chk("R5 dir readback", rd, m_dir);
      for (int m = 0; m < 256; m++) begin
        data_wr(8'(m), 8'(m * 37) ^ 8'h5A);
        chk("R2 R6 pad_out", pad_out, m_out);
        pin_val = (m_dir & m_out) | (~m_dir & pad_in);
        bus_rd(data_addr(8'(m)), rd);
        chk("R4 R8 R10 masked read", rd, pin_val & 8'(m));
      end
    end

    // R3: write to input pins is dropped, visible only after turning to output
    set_dir(8'h00);
    data_wr(8'hFF, 8'hFF);
    chk("R3 inputs hold", pad_out, m_out);
    set_dir(8'hFF);
    chk("R3 held value", pad_out, m_out);
    data_wr(8'hFF, 8'hC3);
    chk("R3 rewrite after output", pad_out, 8'hC3);

    // R8: output pins ignore pad_in
    pad_in = ~m_out;
    repeat (3) @(negedge clk);
    bus_rd(data_addr(8'hFF), rd); chk("R8 driven readback", rd, m_out);

    // R7: two-flop synchroniser latency on inputs
    set_dir(8'h00);
    pad_in = 8'h00;
    repeat (3) @(negedge clk);
    pad_in = 8'h5B;
    @(negedge clk);
    bus_rd(data_addr(8'hFF), rd); chk("R7 one edge", rd, 8'h00);
    @(negedge clk);
    bus_rd(data_addr(8'hFF), rd); chk("R7 two edges", rd, 8'h5B);
    bus_rd(data_addr(8'h0F), rd); chk("R7 R4 partial mask", rd, 8'h0B);

    // R9: unimplemented offsets
    set_dir(8'h5A);
    data_wr(8'hFF, 8'h33);
    foreach (bad_addrs[i]) begin
      bus_wr(bad_addrs[i], 8'hFF ^ 8'(i));
      chk("R9 oe untouched", pad_oe, m_dir);
      chk("R9 out untouched", pad_out, m_out);
      bus_rd(bad_addrs[i], rd); chk("R9 reads zero", rd, 8'h00);
    end
    bus_rd(12'h400, rd); chk("R5 R9 dir after stray", rd, 8'h5A);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule